// File: doc/BRIEF.md
# ISA-Style Peripheral Chip-Select Bridge

The bridge sits between a simple host I/O port (request and acknowledge) and an ISA-style 8-bit peripheral bus. Each host access is compared against four programmable base addresses. Each base claims an aligned block of eight I/O addresses. When an access falls in a block, the bridge runs one peripheral cycle:
- The chip select for that block goes low and the three address lines carry the offset within the block.
- After one setup clock, the read or write strobe is held low for a programmable number of clocks.
- The strobe is released one clock before the chip select.
- Read data is captured at the clock edge where the strobe rises and is returned with the acknowledge.

An access that hits no block produces no bus activity. It is acknowledged at once, and a read returns 0xFF.

The bridge also merges interrupt requests into one active-low shared interrupt output:
- two internal serial-port requests, active high;
- four external active-high requests;
- one external active-low request.

A three-bit mask can silence each serial-port source on its own, and the whole external group at once. The bridge also provides a peripheral reset as a complementary pair of outputs.

Top module: `isa_window_bridge`

## Requirements
- R1: While `rst_n` is low: all chip selects are high, both strobes are high, the data output enable is low, `host_ack` is low, `irq_n` is high, `isa_rst` is 1 and `isa_rst_n` is 0.
- R2: Window i (0..3) is base `win_base[16*i+15:16*i]`. An address hits window i when bits 15:3 of the address equal bits 15:3 of that base; bits 2:0 of the base are ignored. A hit drives `isa_cs_n[i]` low. At most one chip select is low at any time.
- R3: Throughout a peripheral cycle, `isa_a` equals bits 2:0 of the host address that started the cycle.
- R4: The cycle runs in this order, with N = `strobe_clks` (0 is treated as 1):
  - one clock with the chip select low and both strobes high;
  - N clocks with the strobe low;
  - one clock with the strobe high and the chip select still low.
  After that the chip select goes high and `host_ack` pulses high for exactly one clock.
- R5: A write (`host_wr`=1) pulses only `isa_iow_n`. `isa_d_oe` is 1 and `isa_d_o` carries `host_wdata` from the setup clock through the hold clock. `isa_d_oe` is never 1 while `isa_ior_n` is low.
- R6: A read (`host_wr`=0) pulses only `isa_ior_n`. `host_rdata` shown with the acknowledge equals `isa_d_i` as sampled at the clock edge where `isa_ior_n` returns high.
- R7: When an address lies in several windows, the lowest-numbered window wins.
- R8: An access that hits no window causes no chip select and no strobe. It is acknowledged on the next clock edge, with `host_rdata` = 0xFF.
- R9: `irq_n`, registered one clock after its inputs, is low exactly when at least one of these holds:
  - `uart_irq[0]`=1 with `irq_mask[0]`=0;
  - `uart_irq[1]`=1 with `irq_mask[1]`=0;
  - `irq_mask[2]`=0 and (any `ext_irq` bit is 1, or `ext_irq_n` is 0).
- R10: `isa_rst` and `isa_rst_n` are always complementary. `isa_rst` is asserted during reset and drops at the first clock edge after `rst_n` rises.
- R11: A new request is accepted only when the bridge is idle and is not acknowledging. Changing the host address, data or direction during a cycle has no effect on that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_req | input | 1 | Host access request, held until acknowledged |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 16 | Host I/O address |
| host_wdata | input | 8 | Write data |
| host_ack | output | 1 | One-clock completion pulse |
| host_rdata | output | 8 | Read data, valid with `host_ack` |
| win_base | input | 64 | Four 16-bit window bases |
| strobe_clks | input | 4 | Strobe low length in clocks (0 acts as 1) |
| isa_cs_n | output | 4 | Per-window chip selects, active low |
| isa_a | output | 3 | Register offset within the window |
| isa_ior_n | output | 1 | Read strobe, active low |
| isa_iow_n | output | 1 | Write strobe, active low |
| isa_d_o | output | 8 | Data bus output value |
| isa_d_oe | output | 1 | Data bus output enable |
| isa_d_i | input | 8 | Data bus input value |
| isa_rst | output | 1 | Peripheral reset, active high |
| isa_rst_n | output | 1 | Peripheral reset, active low |
| uart_irq | input | 2 | Internal serial-port interrupts, active high |
| ext_irq | input | 4 | External interrupts, active high |
| ext_irq_n | input | 1 | External interrupt, active low |
| irq_mask | input | 3 | Bit 0 / bit 1 mask serial port 0 / 1; bit 2 masks all external sources |
| irq_n | output | 1 | Shared interrupt, active low |

## Verification
Accesses are issued in several patterns, and each pattern separates a different fault:
- Writes and reads to each of the four windows, with strobe lengths 0, 1, 2 and 5, separate the window index from the offset, the direction from the strobe choice, and the off-by-one cases in the strobe count.
- An address at the top offset of a block, and the first address past it, pin down the block boundary.
- Two windows given the same base show which one has priority.
- A host address changed mid-cycle shows whether the request is latched once.
- The interrupt inputs are stepped one source at a time, each with and without its mask bit, so that a swapped mask bit or a wrong polarity shows up on `irq_n`.

// File: rtl/isa_bridge_pkg.sv
package isa_bridge_pkg;

  localparam int OFF_W  = 3;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    CYC_IDLE,
    CYC_SETUP,
    CYC_STROBE,
    CYC_HOLD
  } cyc_state_e;

  // true when both addresses fall in the same aligned 8-register block
  function automatic logic in_window(input logic [31:0] a, input logic [31:0] b);
    return ((a ^ b) >> OFF_W) == 32'd0;
  endfunction

  // strobe length in clocks; a programmed zero is stretched to one
  function automatic int unsigned strobe_len(input logic [31:0] raw);
    return (raw == 32'd0) ? 32'd1 : raw;
  endfunction

endpackage

// File: rtl/isa_win_decode.sv
module isa_win_decode
  import isa_bridge_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int NUM_WIN = 4,
  localparam int IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic [ADDR_W-1:0]         addr,
  input  logic [NUM_WIN*ADDR_W-1:0] bases,
  output logic                      hit,
  output logic [IDX_W-1:0]          idx,
  output logic [OFF_W-1:0]          off
);

  logic [NUM_WIN-1:0] match;

  generate
    for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_win
      assign match[gi] = in_window(32'(addr), 32'(bases[gi*ADDR_W +: ADDR_W]));
    end
  endgenerate

  // lowest-numbered matching window takes priority
  always_comb begin
    idx = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (match[i]) idx = IDX_W'(i);
    end
  end

  assign hit = |match;
  assign off = addr[OFF_W-1:0];

endmodule

// File: rtl/isa_cycle_seq.sv
module isa_cycle_seq
  import isa_bridge_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter int STB_W   = 4,
  localparam int IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               miss,
  input  logic               wr,
  input  logic [IDX_W-1:0]   idx,
  input  logic [OFF_W-1:0]   off,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [STB_W-1:0]   strobe_clks,
  input  logic [DATA_W-1:0]  d_i,
  output logic [NUM_WIN-1:0] cs_n,
  output logic [OFF_W-1:0]   a,
  output logic               ior_n,
  output logic               iow_n,
  output logic [DATA_W-1:0]  d_o,
  output logic               d_oe,
  output logic               ack,
  output logic [DATA_W-1:0]  rdata,
  output logic               busy
);

  cyc_state_e       st;
  logic [STB_W-1:0] cnt;
  logic             wr_q;

  assign busy = (st != CYC_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= CYC_IDLE;
      cnt   <= '0;
      wr_q  <= 1'b0;
      cs_n  <= '1;
      a     <= '0;
      ior_n <= 1'b1;
      iow_n <= 1'b1;
      d_o   <= '0;
      d_oe  <= 1'b0;
      ack   <= 1'b0;
      rdata <= '0;
    end else begin
      ack <= 1'b0;
      unique case (st)
        CYC_IDLE: begin
          if (start) begin
            st   <= CYC_SETUP;
            cs_n <= ~(NUM_WIN'(1) << idx);
            a    <= off;
            wr_q <= wr;
            d_o  <= wdata;
            d_oe <= wr;
          end else if (miss) begin
            ack   <= 1'b1;
            rdata <= '1;
          end
        end
        CYC_SETUP: begin
          st  <= CYC_STROBE;
          cnt <= STB_W'(strobe_len(32'(strobe_clks)) - 1);
          if (wr_q) iow_n <= 1'b0;
          else      ior_n <= 1'b0;
        end
        CYC_STROBE: begin
          if (cnt == '0) begin
            st    <= CYC_HOLD;
            ior_n <= 1'b1;
            iow_n <= 1'b1;
            if (!wr_q) rdata <= d_i;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        CYC_HOLD: begin
          st   <= CYC_IDLE;
          cs_n <= '1;
          d_oe <= 1'b0;
          ack  <= 1'b1;
        end
        default: st <= CYC_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/isa_irq_merge.sv
module isa_irq_merge #(
  parameter int NUM_UART = 2,
  parameter int NUM_HI   = 4,
  parameter int NUM_LO   = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_UART-1:0] uart_irq,
  input  logic [NUM_HI-1:0]   ext_irq,
  input  logic [NUM_LO-1:0]   ext_irq_n,
  input  logic [NUM_UART:0]   irq_mask,
  output logic                irq_n
);

  logic uart_any;
  logic ext_any;
  logic req_any;

  assign uart_any = |(uart_irq & ~irq_mask[NUM_UART-1:0]);
  assign ext_any  = ((|ext_irq) | ~(&ext_irq_n)) & ~irq_mask[NUM_UART];
  assign req_any  = uart_any | ext_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_n <= 1'b1;
    else        irq_n <= ~req_any;
  end

endmodule

// File: rtl/isa_window_bridge.sv
module isa_window_bridge
  import isa_bridge_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int NUM_WIN  = 4,
  parameter int STB_W    = 4,
  parameter int NUM_UART = 2,
  parameter int NUM_HI   = 4,
  parameter int NUM_LO   = 1,
  localparam int IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      host_req,
  input  logic                      host_wr,
  input  logic [ADDR_W-1:0]         host_addr,
  input  logic [7:0]                host_wdata,
  output logic                      host_ack,
  output logic [7:0]                host_rdata,
  input  logic [NUM_WIN*ADDR_W-1:0] win_base,
  input  logic [STB_W-1:0]          strobe_clks,
  output logic [NUM_WIN-1:0]        isa_cs_n,
  output logic [2:0]                isa_a,
  output logic                      isa_ior_n,
  output logic                      isa_iow_n,
  output logic [7:0]                isa_d_o,
  output logic                      isa_d_oe,
  input  logic [7:0]                isa_d_i,
  output logic                      isa_rst,
  output logic                      isa_rst_n,
  input  logic [NUM_UART-1:0]       uart_irq,
  input  logic [NUM_HI-1:0]         ext_irq,
  input  logic [NUM_LO-1:0]         ext_irq_n,
  input  logic [NUM_UART:0]         irq_mask,
  output logic                      irq_n
);

  logic             dec_hit;
  logic [IDX_W-1:0] dec_idx;
  logic [OFF_W-1:0] dec_off;
  logic             seq_busy;
  logic             accept;
  logic             cyc_start;
  logic             cyc_miss;
  logic             per_rst_q;

  isa_win_decode #(.ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN)) u_dec (
    .addr  (host_addr),
    .bases (win_base),
    .hit   (dec_hit),
    .idx   (dec_idx),
    .off   (dec_off)
  );

  // a request is taken only when idle and not in the acknowledge clock
  assign accept    = host_req && !host_ack && !seq_busy;
  assign cyc_start = accept && dec_hit;
  assign cyc_miss  = accept && !dec_hit;

  isa_cycle_seq #(.NUM_WIN(NUM_WIN), .STB_W(STB_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (cyc_start),
    .miss        (cyc_miss),
    .wr          (host_wr),
    .idx         (dec_idx),
    .off         (dec_off),
    .wdata       (host_wdata),
    .strobe_clks (strobe_clks),
    .d_i         (isa_d_i),
    .cs_n        (isa_cs_n),
    .a           (isa_a),
    .ior_n       (isa_ior_n),
    .iow_n       (isa_iow_n),
    .d_o         (isa_d_o),
    .d_oe        (isa_d_oe),
    .ack         (host_ack),
    .rdata       (host_rdata),
    .busy        (seq_busy)
  );

  isa_irq_merge #(.NUM_UART(NUM_UART), .NUM_HI(NUM_HI), .NUM_LO(NUM_LO)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .uart_irq  (uart_irq),
    .ext_irq   (ext_irq),
    .ext_irq_n (ext_irq_n),
    .irq_mask  (irq_mask),
    .irq_n     (irq_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) per_rst_q <= 1'b1;
    else        per_rst_q <= 1'b0;
  end

  assign isa_rst   = per_rst_q;
  assign isa_rst_n = ~per_rst_q;

endmodule

// File: rtl/isa_window_bridge_chk.sv
module isa_window_bridge_chk #(
  parameter int NUM_WIN  = 4,
  parameter int NUM_UART = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               host_ack,
  input logic [7:0]         host_rdata,
  input logic [NUM_WIN-1:0] isa_cs_n,
  input logic [2:0]         isa_a,
  input logic               isa_ior_n,
  input logic               isa_iow_n,
  input logic               isa_d_oe,
  input logic [NUM_UART:0]  irq_mask,
  input logic               irq_n,
  input logic               cyc_miss,
  input logic               isa_rst
);

  assert_cs_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~isa_cs_n));

  assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&isa_cs_n) && $past(!(&isa_cs_n))) |-> $stable(isa_a));

  assert_strobe_in_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!isa_ior_n || !isa_iow_n) |-> !(&isa_cs_n));

  assert_strobe_rise_before_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(isa_ior_n) || $rose(isa_iow_n) |-> !(&isa_cs_n));

  assert_cs_release_after_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(&isa_cs_n) |-> $past(isa_ior_n && isa_iow_n));

  assert_ack_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |=> !host_ack);

  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!isa_ior_n && !isa_iow_n));

  assert_no_drive_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    isa_d_oe |-> isa_ior_n);

  assert_miss_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_miss |=> (host_ack && host_rdata == 8'hFF && &isa_cs_n));

  assert_all_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (&irq_mask) |=> irq_n);

  assert_rst_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> !isa_rst);

endmodule

bind isa_window_bridge isa_window_bridge_chk #(.NUM_WIN(NUM_WIN), .NUM_UART(NUM_UART)) u_chk (.*);

// File: tb/isa_window_bridge_bench.sv
module isa_window_bridge_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_req = 1'b0;
  logic        host_wr = 1'b0;
  logic [15:0] host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic        host_ack;
  logic [7:0]  host_rdata;
  logic [63:0] win_base;
  logic [3:0]  strobe_clks = 4'd1;
  logic [3:0]  isa_cs_n;
  logic [2:0]  isa_a;
  logic        isa_ior_n, isa_iow_n;
  logic [7:0]  isa_d_o;
  logic        isa_d_oe;
  logic [7:0]  isa_d_i;
  logic        isa_rst, isa_rst_n;
  logic [1:0]  uart_irq = '0;
  logic [3:0]  ext_irq = '0;
  logic [0:0]  ext_irq_n = 1'b1;
  logic [2:0]  irq_mask = '0;
  logic        irq_n;

  int tests = 0;
  int fails = 0;
  logic [7:0] salt = 8'h30;

  always #5 clk = ~clk;

  isa_window_bridge u_isa_window_bridge (.*);

  function automatic int cs_index(input logic [3:0] c);
    for (int i = 0; i < 4; i++) if (!c[i]) return i;
    return 0;
  endfunction

  function automatic logic [7:0] dev_byte(input logic [7:0] s, input int w, input int o);
    return s ^ 8'(w * 16 + o);
  endfunction

  // peripheral model: drives a known byte only while being read
  assign isa_d_i = !isa_ior_n ? dev_byte(salt, cs_index(isa_cs_n), int'(isa_a)) : 8'h5A;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- cycle-by-cycle reference model ----------------
  bit         m_busy = 0;
  int         m_k = 0;
  int         m_len = 1;
  int         m_win = 0;
  int         m_off = 0;
  bit         m_wr = 0;
  logic [7:0] m_wd = '0;
  logic [3:0] e_cs = '1;
  logic [2:0] e_a = '0;
  logic       e_ior = 1, e_iow = 1, e_oe = 0, e_ack = 0;
  logic [7:0] e_rdata = '0;
  bit         e_rd_valid = 0;
  logic       e_irq_n = 1, e_prst = 1;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; e_cs = '1; e_ior = 1; e_iow = 1; e_oe = 0; e_ack = 0;
      e_irq_n = 1; e_prst = 1;
    end else begin
      bit src;
      bit was_ack;
      e_prst = 0;
      src = (uart_irq[0] && !irq_mask[0]) || (uart_irq[1] && !irq_mask[1]) ||
            (!irq_mask[2] && (ext_irq != 0 || ext_irq_n[0] == 1'b0));
      e_irq_n = !src;
      was_ack = e_ack;
      e_ack = 0;
      if (m_busy) begin
        m_k++;
        if (m_k == 1) begin
          if (m_wr) e_iow = 0; else e_ior = 0;
        end
        if (m_k == m_len + 1) begin
          e_ior = 1; e_iow = 1;
          if (!m_wr) e_rdata = dev_byte(salt, m_win, m_off);
        end
        if (m_k == m_len + 2) begin
          m_busy = 0; e_cs = '1; e_oe = 0; e_ack = 1; e_rd_valid = !m_wr;
        end
      end else if (host_req && !was_ack) begin
        int w;
        w = -1;
        for (int i = 3; i >= 0; i--)
          if ((host_addr >> 3) == (win_base[16*i +: 16] >> 3)) w = i;
        if (w >= 0) begin
          m_busy = 1; m_k = 0; m_win = w; m_off = int'(host_addr[2:0]);
          m_wr = host_wr; m_wd = host_wdata;
          m_len = (strobe_clks == 0) ? 1 : int'(strobe_clks);
          e_cs = ~(4'b0001 << w); e_a = host_addr[2:0]; e_oe = host_wr;
        end else begin
          e_ack = 1; e_rdata = 8'hFF; e_rd_valid = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    check(rst_n ? "R2 cs" : "R1 cs", 16'(isa_cs_n), 16'(e_cs));
    check(rst_n ? "R4 ior" : "R1 ior", 16'(isa_ior_n), 16'(e_ior));
    check(rst_n ? "R4 iow" : "R1 iow", 16'(isa_iow_n), 16'(e_iow));
    check(rst_n ? "R5 oe" : "R1 oe", 16'(isa_d_oe), 16'(e_oe));
    check(rst_n ? "R4 ack" : "R1 ack", 16'(host_ack), 16'(e_ack));
    check(rst_n ? "R9 irq" : "R1 irq", 16'(irq_n), 16'(e_irq_n));
    check("R10 rst", {14'd0, isa_rst, isa_rst_n}, {14'd0, e_prst, !e_prst});
    if (m_busy) check("R3 addr", 16'(isa_a), 16'(e_a));
    if (e_oe) check("R5 wdata", 16'(isa_d_o), 16'(m_wd));
    if (e_ack && e_rd_valid) check("R6 rdata", 16'(host_rdata), 16'(e_rdata));
  end

  // ---------------- stimulus ----------------
  task automatic access(input logic wr, input logic [15:0] addr, input logic [7:0] wd,
                        input bit chg, output logic [7:0] rd, output int lo,
                        output logic [3:0] cs_acc);
    int n;
    n = 0;
    @(negedge clk);
    host_req = 1; host_wr = wr; host_addr = addr; host_wdata = wd;
    lo = 0; cs_acc = '1;
    do begin
      @(negedge clk);
      n++;
      cs_acc &= isa_cs_n;
      if (!isa_ior_n || !isa_iow_n) lo++;
      if (chg && n == 2) begin host_addr = 16'h03F9; host_wr = !wr; end
    end while (!host_ack && n < 64);
    rd = host_rdata;
    host_req = 0; host_wr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int lo;
    logic [3:0] csa;
    rst_n = 1'b0;
    win_base = {16'h03F8, 16'h02E8, 16'h0305, 16'hD800};
    repeat (3) @(negedge clk);
    check("R1 reset cs", 16'(isa_cs_n), 16'h000F);
    check("R1 reset rst pair", {14'd0, isa_rst, isa_rst_n}, 16'h0002);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 released", 16'(isa_rst), 16'h0000);

    // R5 write to window 0, offset 3, N=2
    strobe_clks = 4'd2;
    access(1, 16'hD803, 8'hC3, 0, rd, lo, csa);
    check("R5 write strobe clocks", 16'(lo), 16'd2);
    check("R2 write window0", 16'(csa), 16'h000E);

    // R6 read window 1 (base low bits ignored), offset 7, N=1
    strobe_clks = 4'd1; salt = 8'h61;
    access(0, 16'h0307, 8'h00, 0, rd, lo, csa);
    check("R6 read data", 16'(rd), 16'(dev_byte(8'h61, 1, 7)));
    check("R2 read window1", 16'(csa), 16'h000D);

    // R4 strobe length zero acts as one
    strobe_clks = 4'd0;
    access(1, 16'h03F8, 8'h3C, 0, rd, lo, csa);
    check("R4 zero length strobe", 16'(lo), 16'd1);

    // R4 long strobe on a read of window 2
    strobe_clks = 4'd5; salt = 8'h92;
    access(0, 16'h02ED, 8'h00, 0, rd, lo, csa);
    check("R4 long strobe", 16'(lo), 16'd5);
    check("R6 read window2", 16'(rd), 16'(dev_byte(8'h92, 2, 5)));

    // R2 top of block, then R8 first address past it
    strobe_clks = 4'd1; salt = 8'h17;
    access(0, 16'hD807, 8'h00, 0, rd, lo, csa);
    check("R2 block top", 16'(rd), 16'(dev_byte(8'h17, 0, 7)));
    access(0, 16'hD808, 8'h00, 0, rd, lo, csa);
    check("R8 miss read data", 16'(rd), 16'h00FF);
    check("R8 miss no strobe", 16'(lo), 16'd0);
    check("R8 miss no cs", 16'(csa), 16'h000F);
    access(1, 16'h1234, 8'hAA, 0, rd, lo, csa);
    check("R8 miss write no strobe", 16'(lo), 16'd0);

    // R7 overlapping windows: 0 and 2 share a base
    win_base[47:32] = 16'hD800;
    access(1, 16'hD804, 8'h44, 0, rd, lo, csa);
    check("R7 lowest window wins", 16'(csa), 16'h000E);
    win_base[47:32] = 16'h02E8;

    // R11 address and direction changed mid-cycle are ignored
    strobe_clks = 4'd3;
    access(1, 16'h0302, 8'h55, 1, rd, lo, csa);
    check("R11 cs unchanged", 16'(csa), 16'h000D);
    check("R11 strobe count", 16'(lo), 16'd3);

    // R9 interrupt merging, one source at a time
    @(negedge clk); uart_irq = 2'b01; irq_mask = 3'b000;
    repeat (2) @(negedge clk);
    check("R9 uart0 unmasked", 16'(irq_n), 16'd0);
    irq_mask = 3'b001; repeat (2) @(negedge clk);
    check("R9 uart0 masked", 16'(irq_n), 16'd1);
    irq_mask = 3'b010; repeat (2) @(negedge clk);
    check("R9 uart0 wrong mask bit", 16'(irq_n), 16'd0);
    uart_irq = 2'b10; irq_mask = 3'b010; repeat (2) @(negedge clk);
    check("R9 uart1 masked", 16'(irq_n), 16'd1);
    uart_irq = 2'b00; ext_irq = 4'b1000; irq_mask = 3'b000; repeat (2) @(negedge clk);
    check("R9 ext high", 16'(irq_n), 16'd0);
    irq_mask = 3'b100; repeat (2) @(negedge clk);
    check("R9 ext masked", 16'(irq_n), 16'd1);
    ext_irq = 4'b0000; ext_irq_n = 1'b0; irq_mask = 3'b011; repeat (2) @(negedge clk);
    check("R9 ext low active", 16'(irq_n), 16'd0);
    irq_mask = 3'b100; repeat (2) @(negedge clk);
    check("R9 ext low masked", 16'(irq_n), 16'd1);
    ext_irq_n = 1'b1; irq_mask = 3'b000; repeat (2) @(negedge clk);
    check("R9 all idle", 16'(irq_n), 16'd1);

    // R10 reset again mid-run
    rst_n = 1'b0; repeat (2) @(negedge clk);
    check("R10 asserted", {14'd0, isa_rst, isa_rst_n}, 16'h0002);
    rst_n = 1'b1; repeat (2) @(negedge clk);
    check("R10 deasserted", {14'd0, isa_rst, isa_rst_n}, 16'h0001);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule